// File: doc/BRIEF.md
# Warp Memory Replay Sequencer

This block takes a single warp-wide load: an active-thread mask with one bit per thread and one byte address per thread. It breaks the load into a series of cache issues. Each issue does one tag lookup, so it can only cover threads whose addresses share one cache line. The sequencer takes the lowest-numbered thread that is still pending as the reference for the next issue. That issue serves every pending thread in the reference thread's line. The served threads are then removed, and the sequencer repeats until no thread is left. At that point the instruction retires.

Each issue is answered by a one-cycle hit/miss response. A miss on a normal issue causes one extra replay of the same line and mask. That replay stands for the fill.

Two saturating counters track the work. One counts issues, replays included. The other counts retired instructions. The gap between them is the replay overhead that scattered or missing accesses cost.

Top module: `warp_replay_seq`

## Requirements
- R1: After reset, req_ready is 1, iss_valid and done are 0, and both counters read 0.
- R2: A request is taken on a cycle where req_valid and req_ready are both 1. While an instruction with a nonzero mask is in progress, req_ready stays 0.
- R3: Each issue is built from the lowest-numbered pending thread. iss_line is that thread's address with its low 7 bits cleared (128-byte line). iss_mask has bit t set exactly for each pending thread t whose address lies in that same line.
- R4: After a normal or fill issue completes, the threads in its iss_mask are removed from the pending set. Issues continue until the pending set is empty, so the number of normal issues equals the number of distinct lines among the active threads.
- R5: iss_replay is 0 on the first issue of an instruction and 1 on every later issue of that instruction, fill replays included.
- R6: A response with rsp_hit=0 to a normal issue produces exactly one fill replay, with the same iss_line and iss_mask. The hit value in the response to a fill replay is ignored.
- R7: issued_cnt increases by 1 for every cycle in which iss_valid is 1.
- R8: On retirement, done is 1 for exactly one cycle and executed_cnt increases by 1. For a nonzero mask, done appears in the cycle after the last response is sampled.
- R9: A request with an all-zero mask makes no issue. It raises done in the next cycle and adds 1 to both counters.
- R10: Both counters hold at their maximum value instead of wrapping.
- R11: cnt_clear sets both counters to 0 at the next clock edge and takes priority over any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A load instruction is offered |
| req_ready | output | 1 | Sequencer is idle and can accept |
| req_mask | input | THREADS | Active-thread mask |
| req_addr | input | THREADS*ADDR_W | Per-thread byte addresses, thread t in bits [t*ADDR_W +: ADDR_W] |
| iss_valid | output | 1 | An issue is presented this cycle |
| iss_line | output | ADDR_W | Line address of the issue |
| iss_mask | output | THREADS | Threads served by the issue |
| iss_replay | output | 1 | Issue is not the first of its instruction |
| rsp_valid | input | 1 | Response to the outstanding issue |
| rsp_hit | input | 1 | Response result: 1 hit, 0 miss |
| done | output | 1 | One-cycle retirement pulse |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| issued_cnt | output | CNT_W | Saturating count of issues and replays |
| executed_cnt | output | CNT_W | Saturating count of retired instructions |

## Verification
A corrupted pending mask shows up at the very next issue. It either serves a thread already served or skips one, so iss_mask or the number of issues differs from the line grouping the bench computes from the addresses. A lost fill flag or first-issue flag shows up as a wrong iss_replay bit, or as a missing or extra replay on the issue that follows the response. Counter faults are caught when done arrives, because both counts are compared against running totals kept in the bench, including the saturation runs.

// File: rtl/warp_replay_pkg.sv
package warp_replay_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wrs_line_group.sv
module wrs_line_group #(
  parameter int THREADS = 32,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 7
) (
  input  logic [THREADS-1:0]        pend,
  input  logic [THREADS*ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0]         line_addr,
  output logic [THREADS-1:0]        served
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0] tag [THREADS];
  logic [TAG_W-1:0] ref_tag;
  logic             found;

  genvar t;
  generate
    for (t = 0; t < THREADS; t++) begin : g_tag
      assign tag[t]    = addr[t*ADDR_W+OFS_W +: TAG_W];
      assign served[t] = pend[t] && (tag[t] == ref_tag);
    end
  endgenerate

  // lowest pending thread supplies the reference line
  always_comb begin
    ref_tag = '0;
    found   = 1'b0;
    for (int i = 0; i < THREADS; i++) begin
      if (pend[i] && !found) begin
        ref_tag = tag[i];
        found   = 1'b1;
      end
    end
  end

  assign line_addr = {ref_tag, {OFS_W{1'b0}}};
endmodule

// File: rtl/wrs_sat_cnt.sv
module wrs_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/warp_replay_seq.sv
module warp_replay_seq
  import warp_replay_pkg::*;
#(
  parameter int THREADS    = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int CNT_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [THREADS-1:0]        req_mask,
  input  logic [THREADS*ADDR_W-1:0] req_addr,
  output logic                      iss_valid,
  output logic [ADDR_W-1:0]         iss_line,
  output logic [THREADS-1:0]        iss_mask,
  output logic                      iss_replay,
  input  logic                      rsp_valid,
  input  logic                      rsp_hit,
  output logic                      done,
  input  logic                      cnt_clear,
  output logic [CNT_W-1:0]          issued_cnt,
  output logic [CNT_W-1:0]          executed_cnt
);
  localparam int OFS_W = $clog2(LINE_BYTES);

  seq_state_t                state_q;
  logic [THREADS*ADDR_W-1:0] addr_q;
  logic [THREADS-1:0]        pend_q;
  logic                      first_q;
  logic                      fill_q;

  logic [ADDR_W-1:0]  grp_line;
  logic [THREADS-1:0] grp_mask;
  logic [THREADS-1:0] pend_after;
  logic               accept;
  logic               need_fill;
  logic               inc_iss;
  logic               inc_exe;

  wrs_line_group #(
    .THREADS (THREADS),
    .ADDR_W  (ADDR_W),
    .OFS_W   (OFS_W)
  ) u_group (
    .pend      (pend_q),
    .addr      (addr_q),
    .line_addr (grp_line),
    .served    (grp_mask)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign pend_after = pend_q & ~iss_mask;
  assign need_fill  = !fill_q && !rsp_hit;

  always_comb begin
    inc_iss = 1'b0;
    inc_exe = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept && (req_mask == '0)) begin
          inc_iss = 1'b1;
          inc_exe = 1'b1;
        end
      end
      ST_ISSUE: inc_iss = 1'b1;
      ST_WAIT: begin
        if (rsp_valid) begin
          if (need_fill) inc_iss = 1'b1;
          else if (pend_after == '0) inc_exe = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      pend_q     <= '0;
      first_q    <= 1'b0;
      fill_q     <= 1'b0;
      iss_valid  <= 1'b0;
      iss_line   <= '0;
      iss_mask   <= '0;
      iss_replay <= 1'b0;
      done       <= 1'b0;
    end else begin
      iss_valid <= 1'b0;
      done      <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            pend_q  <= req_mask;
            first_q <= 1'b1;
            if (req_mask == '0) done <= 1'b1;
            else state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          iss_valid  <= 1'b1;
          iss_line   <= grp_line;
          iss_mask   <= grp_mask;
          iss_replay <= !first_q;
          first_q    <= 1'b0;
          fill_q     <= 1'b0;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (need_fill) begin
              iss_valid  <= 1'b1;
              iss_replay <= 1'b1;
              fill_q     <= 1'b1;
            end else begin
              pend_q <= pend_after;
              if (pend_after == '0) begin
                done    <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_ISSUE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  wrs_sat_cnt #(.CNT_W(CNT_W)) u_iss_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clear),
    .inc (inc_iss),
    .cnt (issued_cnt)
  );

  wrs_sat_cnt #(.CNT_W(CNT_W)) u_exe_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clear),
    .inc (inc_exe),
    .cnt (executed_cnt)
  );
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk #(
  parameter int THREADS = 32,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [THREADS-1:0] req_mask,
  input logic               iss_valid,
  input logic [THREADS-1:0] iss_mask,
  input logic               done,
  input logic               cnt_clear,
  input logic [CNT_W-1:0]   issued_cnt,
  input logic [CNT_W-1:0]   executed_cnt
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_mask != '0)) |=> !req_ready);

  // R2
  issue_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (!req_ready && (iss_mask != '0)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> ((issued_cnt == '0) && (executed_cnt == '0)));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_clear |=> ((issued_cnt >= $past(issued_cnt)) && (executed_cnt >= $past(executed_cnt))));

  // R8
  exe_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_clear) && (executed_cnt != $past(executed_cnt))) |-> done);

  // R7
  iss_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_clear) && (issued_cnt != $past(issued_cnt))) |-> (iss_valid || done));
endmodule

bind warp_replay_seq wrs_chk #(.THREADS(THREADS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_mask     (req_mask),
  .iss_valid    (iss_valid),
  .iss_mask     (iss_mask),
  .done         (done),
  .cnt_clear    (cnt_clear),
  .issued_cnt   (issued_cnt),
  .executed_cnt (executed_cnt)
);

// File: tb/warp_replay_seq_tb.sv
module warp_replay_seq_tb;
  localparam int TH  = 32;
  localparam int AW  = 32;
  localparam int CW  = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [TH-1:0]  req_mask = '0;
  logic [TH*AW-1:0] req_addr = '0;
  logic           iss_valid;
  logic [AW-1:0]  iss_line;
  logic [TH-1:0]  iss_mask;
  logic           iss_replay;
  logic           rsp_valid = 1'b0;
  logic           rsp_hit = 1'b0;
  logic           done;
  logic           cnt_clear = 1'b0;
  logic [CW-1:0]  issued_cnt;
  logic [CW-1:0]  executed_cnt;

  int checks = 0;
  int fails  = 0;
  int exp_iss = 0;
  int exp_exe = 0;
  logic [31:0] seed = 32'h1234_5679;
  logic [AW-1:0] ta [TH];

  always #5 clk = ~clk;

  warp_replay_seq #(.THREADS(TH), .ADDR_W(AW), .LINE_BYTES(128), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .iss_valid(iss_valid),
    .iss_line(iss_line), .iss_mask(iss_mask), .iss_replay(iss_replay),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .done(done),
    .cnt_clear(cnt_clear), .issued_cnt(issued_cnt), .executed_cnt(executed_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  // mode 0: all hit, 1: every normal issue misses, 2: odd-numbered groups miss
  task automatic run_instr(input logic [TH-1:0] mask, input int mode);
    logic [TH-1:0] pend = mask;
    int grp = 0;
    int nissue = 0;
    for (int t = 0; t < TH; t++) req_addr[t*AW +: AW] = ta[t];
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready when idle", {63'd0, req_ready}, 64'd1);
    req_mask  = mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mask == '0) begin
      exp_iss = sat(exp_iss + 1);
      exp_exe = sat(exp_exe + 1);
      chk(done == 1'b1 && iss_valid == 1'b0, "R9 empty mask done", {62'd0, done, iss_valid}, 64'd2);
      chk(issued_cnt == CW'(exp_iss) && executed_cnt == CW'(exp_exe), "R9 empty mask counts",
          {48'd0, issued_cnt, executed_cnt}, {48'd0, CW'(exp_iss), CW'(exp_exe)});
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
      return;
    end
    while (pend != '0) begin
      int lo = 0;
      logic [AW-1:0] eline;
      logic [TH-1:0] emask = '0;
      bit miss;
      for (int t = TH - 1; t >= 0; t--) if (pend[t]) lo = t;
      eline = {ta[lo][AW-1:7], 7'd0};
      for (int t = 0; t < TH; t++)
        if (pend[t] && ta[t][AW-1:7] == eline[AW-1:7]) emask[t] = 1'b1;
      miss = (mode == 1) || (mode == 2 && grp[0]);
      for (int pass = 0; pass < (miss ? 2 : 1); pass++) begin
        int w = 0;
        while (!iss_valid && w < 20) begin @(negedge clk); w++; end
        if (!iss_valid) begin
          chk(1'b0, "R4 missing issue", 64'd0, 64'd1);
          return;
        end
        exp_iss = sat(exp_iss + 1);
        chk(iss_line == eline, (pass == 0) ? "R3 line" : "R6 fill line", {32'd0, iss_line}, {32'd0, eline});
        chk(iss_mask == emask, (pass == 0) ? "R3 mask" : "R6 fill mask", {32'd0, iss_mask}, {32'd0, emask});
        chk(iss_replay == (nissue != 0), "R5 replay flag", {63'd0, iss_replay}, {63'd0, nissue != 0});
        chk(req_ready == 1'b0, "R2 busy", {63'd0, req_ready}, 64'd0);
        nissue++;
        rsp_valid = 1'b1;
        // fill response carries hit=0 to show it is ignored
        rsp_hit   = (pass == 0) ? !miss : 1'b0;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
      end
      pend = pend & ~emask;
      grp++;
      if (pend != '0) chk(done == 1'b0, "R4 no early done", {63'd0, done}, 64'd0);
    end
    exp_exe = sat(exp_exe + 1);
    chk(done == 1'b1, "R8 done after last response", {63'd0, done}, 64'd1);
    chk(issued_cnt == CW'(exp_iss), "R7 issued count", {56'd0, issued_cnt}, {56'd0, CW'(exp_iss)});
    chk(executed_cnt == CW'(exp_exe), "R8 executed count", {56'd0, executed_cnt}, {56'd0, CW'(exp_exe)});
    @(negedge clk);
    chk(done == 1'b0 && iss_valid == 1'b0, "R8 done one cycle", {62'd0, done, iss_valid}, 64'd0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    exp_iss = 0;
    exp_exe = 0;
    chk(issued_cnt == '0 && executed_cnt == '0, "R11 clear",
        {48'd0, issued_cnt, executed_cnt}, 64'd0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(req_ready && !iss_valid && !done, "R1 reset outputs", {61'd0, req_ready, iss_valid, done}, 64'd4);
    chk(issued_cnt == '0 && executed_cnt == '0, "R1 reset counters", {48'd0, issued_cnt, executed_cnt}, 64'd0);

    // consecutive words in one line: one issue
    for (int t = 0; t < TH; t++) ta[t] = 32'h0000_1000 + 32'(t * 4);
    run_instr('1, 0);
    // distinct lines, all hit: 32 issues
    for (int t = 0; t < TH; t++) ta[t] = 32'h0002_0000 + 32'(t * 128);
    run_instr('1, 0);
    do_clear();
    // same address for all threads
    for (int t = 0; t < TH; t++) ta[t] = 32'h0000_3044;
    run_instr('1, 1);
    // four threads per line, odd groups miss
    for (int t = 0; t < TH; t++) ta[t] = 32'h0004_0010 + 32'(t * 32);
    run_instr(32'hF0F0_0FF1, 2);
    // empty mask
    run_instr('0, 0);
    do_clear();
    // 32 distinct lines all missing: 64 issues
    for (int t = 0; t < TH; t++) ta[t] = 32'h0008_0000 + 32'(t * 128);
    run_instr('1, 1);
    chk(issued_cnt == 8'd64 && executed_cnt == 8'd1, "R6 all-miss totals",
        {48'd0, issued_cnt, executed_cnt}, {48'd0, 8'd64, 8'd1});
    // saturation of issued count
    for (int k = 0; k < 4; k++) run_instr('1, 1);
    chk(issued_cnt == 8'd255, "R10 issued saturates", {56'd0, issued_cnt}, 64'd255);
    do_clear();
    // saturation of executed count via empty masks
    for (int k = 0; k < 260; k++) run_instr('0, 0);
    chk(executed_cnt == 8'd255 && issued_cnt == 8'd255, "R10 both saturate",
        {48'd0, issued_cnt, executed_cnt}, {48'd0, 8'd255, 8'd255});
    do_clear();
    // sweep of masks and scattered addresses over a few lines
    for (int k = 0; k < 60; k++) begin
      logic [TH-1:0] m;
      seed = rnd(seed); m = seed;
      if (k % 7 == 3) m = 32'h8000_0000 >> (k % 32);
      for (int t = 0; t < TH; t++) begin
        seed = rnd(seed);
        ta[t] = 32'h0010_0000 + {22'd0, seed[9:8], 7'd0} + {25'd0, seed[6:0]};
        if (k % 5 == 0) ta[t] = ta[t] + {seed[20:16], 12'd0};
      end
      run_instr(m, k % 3);
    end
    finish_run();
  end
endmodule